// File: doc/BRIEF.md
# USB device packet transmitter

This block serializes one reply from a USB device to the host and drives the two data lines itself, with no separate transceiver chip. A receive engine, outside this block, launches it with a single-clock `start` pulse that carries the reply kind and, for data replies, the data toggle. The reply is either a handshake (ACK, NAK or STALL) or a data packet with an 8-byte payload. The receive engine then waits until the block reports completion.

Bit timing comes from `bit_en`, a one-clock strobe that marks each bit time of the bus. On each strobe the block puts one line symbol on the pins. A packet is made of:
- the synchronization pattern,
- the PID byte,
- for data packets, the payload and then the CRC16,
- bit stuffing and NRZI encoding applied across all of these fields,
- the end-of-packet signalling.

After the end of packet the block releases the pins. The payload is read directly from `tx_bytes` while it is being shifted out. `rd_req` tells the user logic that this array must be held.

Top module: `usb_pkt_tx`

## Requirements
- R1: While `rst_n` is low and right after it rises, `line_oe`, `busy`, `done` and `rd_req` are all 0.
- R2: When no packet is in progress, `line_oe` is 0 and `dp_o`/`dm_o` are both 0, whatever `bit_en` does.
- R3: The first 8 bit times of every packet carry the raw bits 0,0,0,0,0,0,0,1 (byte 0x80 sent least significant bit first).
- R4: The PID byte follows, least significant bit first. It is 0xD2 for ACK (`req_kind`=0), 0x5A for NAK (1), 0x1E for STALL (2), and 0xC3/0x4B for data (`req_kind`=3) with `data_tog` 0/1.
- R5: A data packet carries the 64 bits of `tx_bytes` after the PID, bit 0 first and bit 63 last.
- R6: After the payload come 16 CRC bits. The CRC register starts at 0xFFFF and shifts left on each payload bit. Its feedback is the payload bit XOR the register MSB, and when that feedback is 1 the register is XORed with 0x8005. The complemented register is sent MSB of the register first.
- R7: After six consecutive raw 1 bits, counted from the start of the synchronization pattern, one 0 bit is inserted. This includes a run that ends on the last CRC or PID bit.
- R8: Every bit time up to the end of packet is a J (`dp_o`=1, `dm_o`=0) or K (0,1) state with `line_oe`=1. A 0 bit changes the state and a 1 bit keeps it. The line state before the first bit is J.
- R9: After the last bit come two bit times of SE0 (both lines 0) and one bit time of J. On the next bit time `line_oe` drops to 0.
- R10: `busy` is 1 from the clock after an accepted `start` until `done`. `done` is a one-clock pulse on the bit time after the lines are released, and `busy` is 0 with it.
- R11: `rd_req` is 1 from the strobe that sends the last PID bit until the strobe that sends the last payload bit, and 0 at all other times.
- R12: A `start` pulse while `busy` is 1 is ignored, and so are `req_kind` and `data_tog` at that time. The packet in progress goes on unchanged.
- R13: A handshake reply occupies exactly 19 driven bit times: 8 sync, 8 PID and 3 end-of-packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-clock strobe per bus bit time |
| start | input | 1 | Launch pulse from the receive engine |
| req_kind | input | 2 | Reply kind: 0 ACK, 1 NAK, 2 STALL, 3 data |
| data_tog | input | 1 | Data toggle for data replies (0 = DATA0) |
| tx_bytes | input | 64 | Payload, byte 0 in bits 7:0 |
| dp_o | output | 1 | D+ drive value |
| dm_o | output | 1 | D- drive value |
| line_oe | output | 1 | Pad output enable for both lines |
| busy | output | 1 | Packet in progress |
| done | output | 1 | Completion pulse to the receive engine |
| rd_req | output | 1 | Payload is being read from `tx_bytes` |

## Verification
The assertions take for granted four things about the inputs:
- `start` and `bit_en` are synchronous to `clk`.
- `start` is a single-clock pulse.
- `tx_bytes` is held steady while `rd_req` is high.
- `req_kind` and `data_tog` matter only in the clock where a start is accepted.

The stimulus keeps to these assumptions. It issues `bit_en` as one-clock pulses separated by random gaps, and it loads the payload before each launch and leaves it untouched until `done`. Extra `start` pulses carrying a different kind and toggle are injected only while a packet is in flight.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;

  localparam int CRC_W = 16;
  typedef logic [CRC_W-1:0] crc_t;

  // reply kind as presented by the receive engine
  typedef enum logic [1:0] {
    RQ_ACK   = 2'd0,
    RQ_NAK   = 2'd1,
    RQ_STALL = 2'd2,
    RQ_DATA  = 2'd3
  } req_t;

  // what the sequencer will do on the next bit strobe
  typedef enum logic [3:0] {
    PH_IDLE, PH_SYNC, PH_PID, PH_DATA, PH_CRC,
    PH_EOP0, PH_EOP1, PH_JEND, PH_REL, PH_FIN
  } phase_t;

  // line stage command
  typedef enum logic [2:0] {
    LM_OFF, LM_BIT, LM_STUFF, LM_SE0, LM_J
  } lmode_t;

  localparam logic [7:0] SYNC_BYTE = 8'h80;

  // PID nibble plus its complement in the upper half
  function automatic logic [7:0] pid_byte(req_t rq, logic tog);
    logic [3:0] p;
    case (rq)
      RQ_ACK:   p = 4'h2;
      RQ_NAK:   p = 4'hA;
      RQ_STALL: p = 4'hE;
      default:  p = tog ? 4'hB : 4'h3;
    endcase
    return {~p, p};
  endfunction

  // one serial CRC step, MSB-side feedback
  function automatic crc_t crc_step(crc_t c, logic d, crc_t poly);
    crc_t nxt;
    nxt = {c[CRC_W-2:0], 1'b0};
    if (d ^ c[CRC_W-1]) nxt = nxt ^ poly;
    return nxt;
  endfunction

endpackage

// File: rtl/usb_tx_crc.sv
module usb_tx_crc
  import usb_tx_pkg::*;
#(
  parameter crc_t POLY = 16'h8005,
  parameter crc_t INIT = 16'hFFFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  input  logic din,
  output crc_t crc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= INIT;
    else if (clr) crc <= INIT;
    else if (adv) crc <= crc_step(crc, din, POLY);
  end

endmodule

// File: rtl/usb_tx_line.sv
module usb_tx_line
  import usb_tx_pkg::*;
#(
  parameter int MAX_RUN = 6,
  localparam int RW = $clog2(MAX_RUN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  lmode_t        mode,
  input  logic          bit_in,
  output logic          stuff_due,
  output logic [RW-1:0] run_len,
  output logic          dp_o,
  output logic          dm_o,
  output logic          oe_o
);

  logic lvl;       // 1 = J state
  logic send_bit;
  logic nxt_lvl;

  always_comb begin
    send_bit = (mode == LM_BIT) ? bit_in : 1'b0;
    nxt_lvl  = send_bit ? lvl : ~lvl;
  end

  assign stuff_due = (run_len == RW'(MAX_RUN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl     <= 1'b1;
      run_len <= '0;
      dp_o    <= 1'b0;
      dm_o    <= 1'b0;
      oe_o    <= 1'b0;
    end else if (tick) begin
      case (mode)
        LM_BIT, LM_STUFF: begin
          lvl     <= nxt_lvl;
          dp_o    <= nxt_lvl;
          dm_o    <= ~nxt_lvl;
          oe_o    <= 1'b1;
          run_len <= send_bit ? RW'(run_len + 1'b1) : '0;
        end
        LM_SE0: begin
          lvl     <= 1'b1;
          dp_o    <= 1'b0;
          dm_o    <= 1'b0;
          oe_o    <= 1'b1;
          run_len <= '0;
        end
        LM_J: begin
          lvl     <= 1'b1;
          dp_o    <= 1'b1;
          dm_o    <= 1'b0;
          oe_o    <= 1'b1;
          run_len <= '0;
        end
        default: begin
          lvl     <= 1'b1;
          dp_o    <= 1'b0;
          dm_o    <= 1'b0;
          oe_o    <= 1'b0;
          run_len <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/usb_tx_seq.sv
module usb_tx_seq
  import usb_tx_pkg::*;
#(
  parameter int NBYTES = 8,
  localparam int PAY_W = NBYTES * 8,
  localparam int BI_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  req_t             req_in,
  input  logic             tog_in,
  input  logic [PAY_W-1:0] payload,
  input  crc_t             crc_val,
  input  logic             stuff_due,
  output lmode_t           mode,
  output logic             raw_bit,
  output logic             crc_clr,
  output logic             crc_adv,
  output logic             busy,
  output logic             done,
  output logic             rd_req,
  output req_t             req_q
);

  localparam logic [2:0]      BIT_LAST  = 3'd7;
  localparam logic [3:0]      CRC_LAST  = 4'(CRC_W - 1);
  localparam logic [BI_W-1:0] BYTE_LAST = BI_W'(NBYTES - 1);

  phase_t          phase;
  logic [2:0]      bcnt;
  logic [BI_W-1:0] byte_i;
  logic [3:0]      ccnt;
  logic [7:0]      pid_q;
  logic [BI_W+2:0] pidx;
  logic            bit_ph;
  logic            stuff_now;
  logic            step;

  assign pidx      = {byte_i, bcnt};
  assign bit_ph    = (phase == PH_SYNC) || (phase == PH_PID) ||
                     (phase == PH_DATA) || (phase == PH_CRC);
  assign stuff_now = stuff_due && (bit_ph || (phase == PH_EOP0));
  assign step      = tick && !stuff_now;
  assign busy      = (phase != PH_IDLE);
  assign rd_req    = (phase == PH_DATA);
  assign crc_clr   = start && (phase == PH_IDLE);
  assign crc_adv   = step && (phase == PH_DATA);

  always_comb begin
    case (phase)
      PH_SYNC: raw_bit = SYNC_BYTE[bcnt];
      PH_PID:  raw_bit = pid_q[bcnt];
      PH_DATA: raw_bit = payload[pidx];
      PH_CRC:  raw_bit = ~crc_val[CRC_LAST - ccnt];
      default: raw_bit = 1'b0;
    endcase
  end

  always_comb begin
    if (stuff_now)               mode = LM_STUFF;
    else if (bit_ph)             mode = LM_BIT;
    else if (phase == PH_EOP0 ||
             phase == PH_EOP1)   mode = LM_SE0;
    else if (phase == PH_JEND)   mode = LM_J;
    else                         mode = LM_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      bcnt   <= '0;
      byte_i <= '0;
      ccnt   <= '0;
      pid_q  <= '0;
      req_q  <= RQ_ACK;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start) begin
          phase  <= PH_SYNC;
          bcnt   <= '0;
          byte_i <= '0;
          ccnt   <= '0;
          req_q  <= req_in;
          pid_q  <= pid_byte(req_in, tog_in);
        end
      end else if (step) begin
        case (phase)
          PH_SYNC: begin
            bcnt <= bcnt + 3'd1;
            if (bcnt == BIT_LAST) phase <= PH_PID;
          end
          PH_PID: begin
            bcnt <= bcnt + 3'd1;
            if (bcnt == BIT_LAST)
              phase <= (req_q == RQ_DATA) ? PH_DATA : PH_EOP0;
          end
          PH_DATA: begin
            bcnt <= bcnt + 3'd1;
            if (bcnt == BIT_LAST) begin
              if (byte_i == BYTE_LAST) phase  <= PH_CRC;
              else                     byte_i <= byte_i + 1'b1;
            end
          end
          PH_CRC: begin
            ccnt <= ccnt + 4'd1;
            if (ccnt == CRC_LAST) phase <= PH_EOP0;
          end
          PH_EOP0: phase <= PH_EOP1;
          PH_EOP1: phase <= PH_JEND;
          PH_JEND: phase <= PH_REL;
          PH_REL:  phase <= PH_FIN;
          PH_FIN: begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/usb_pkt_tx.sv
module usb_pkt_tx
  import usb_tx_pkg::*;
#(
  parameter int   NBYTES   = 8,
  parameter int   MAX_RUN  = 6,
  parameter crc_t CRC_POLY = 16'h8005,
  parameter crc_t CRC_INIT = 16'hFFFF,
  localparam int  PAY_W    = NBYTES * 8,
  localparam int  RW       = $clog2(MAX_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             start,
  input  logic [1:0]       req_kind,
  input  logic             data_tog,
  input  logic [PAY_W-1:0] tx_bytes,
  output logic             dp_o,
  output logic             dm_o,
  output logic             line_oe,
  output logic             busy,
  output logic             done,
  output logic             rd_req
);

  // internal events brought out for the checker
  lmode_t        mode;
  logic          raw_bit;
  logic          crc_clr;
  logic          crc_adv;
  logic          stuff_due;
  logic [RW-1:0] run_len;
  crc_t          crc_val;
  req_t          req_q;
  logic [1:0]    req_q_bits;

  assign req_q_bits = req_q;

  usb_tx_seq #(.NBYTES(NBYTES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (bit_en),
    .start     (start),
    .req_in    (req_t'(req_kind)),
    .tog_in    (data_tog),
    .payload   (tx_bytes),
    .crc_val   (crc_val),
    .stuff_due (stuff_due),
    .mode      (mode),
    .raw_bit   (raw_bit),
    .crc_clr   (crc_clr),
    .crc_adv   (crc_adv),
    .busy      (busy),
    .done      (done),
    .rd_req    (rd_req),
    .req_q     (req_q)
  );

  usb_tx_crc #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (crc_clr),
    .adv   (crc_adv),
    .din   (raw_bit),
    .crc   (crc_val)
  );

  usb_tx_line #(.MAX_RUN(MAX_RUN)) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (bit_en),
    .mode      (mode),
    .bit_in    (raw_bit),
    .stuff_due (stuff_due),
    .run_len   (run_len),
    .dp_o      (dp_o),
    .dm_o      (dm_o),
    .oe_o      (line_oe)
  );

endmodule

// File: rtl/usb_pkt_tx_chk.sv
module usb_pkt_tx_chk #(
  parameter int MAX_RUN = 6,
  localparam int RW = $clog2(MAX_RUN + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          rd_req,
  input logic          line_oe,
  input logic          dp_o,
  input logic          dm_o,
  input logic [RW-1:0] run_len,
  input logic [1:0]    req_q
);

  // R8: a driven line is never both high
  a_r8_no_se1: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> !(dp_o && dm_o));

  // R2: pins are driven only inside a packet
  a_r2_drive_in_packet: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> busy);

  // R2: released pins carry zeros
  a_r2_release_clean: assert property (@(posedge clk) disable iff (!rst_n)
    !line_oe |-> (!dp_o && !dm_o));

  // R10: done lasts one clock
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: done comes with lines released and busy low
  a_r10_done_released: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!line_oe && !busy));

  // R11: payload read only within a packet
  a_r11_rdreq_in_packet: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> busy);

  // R7: the raw run of ones on the line never exceeds the limit
  a_r7_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= RW'(MAX_RUN));

  // R12: a start during a packet does not change the latched kind
  a_r12_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(req_q));

endmodule

bind usb_pkt_tx usb_pkt_tx_chk #(.MAX_RUN(MAX_RUN)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .rd_req  (rd_req),
  .line_oe (line_oe),
  .dp_o    (dp_o),
  .dm_o    (dm_o),
  .run_len (run_len),
  .req_q   (req_q_bits)
);

// File: tb/sim_usb_pkt_tx.sv
module sim_usb_pkt_tx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic        data_tog = 1'b0;
  logic [63:0] tx_bytes = '0;
  logic        dp_o, dm_o, line_oe, busy, done, rd_req;

  int checks = 0;
  int errors = 0;

  // expected stream model
  logic        rb  [0:127];
  int          rp  [0:127];
  int          nraw;
  logic [1:0]  es  [0:191];
  int          eph [0:191];   // 0 sync 1 pid 2 data 3 crc 4 eop
  logic        est [0:191];   // inserted stuff bit
  int          ns;
  // captured
  logic [1:0]  got    [0:191];
  logic        got_oe [0:191];
  logic        got_rd [0:191];

  usb_pkt_tx u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start(start),
    .req_kind(req_kind), .data_tog(data_tog), .tx_bytes(tx_bytes),
    .dp_o(dp_o), .dm_o(dm_o), .line_oe(line_oe), .busy(busy),
    .done(done), .rd_req(rd_req)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] bench_pid(int k, logic t);
    case (k)
      0:       return 8'hD2;
      1:       return 8'h5A;
      2:       return 8'h1E;
      default: return t ? 8'h4B : 8'hC3;
    endcase
  endfunction

  // reflected form of the same CRC; result already complemented, send bit 0 first
  function automatic logic [15:0] bench_crc(logic [63:0] d);
    logic [15:0] r;
    logic        fb;
    r = 16'hFFFF;
    for (int i = 0; i < 64; i++) begin
      fb = d[i] ^ r[0];
      r  = r >> 1;
      if (fb) r = r ^ 16'hA001;
    end
    return ~r;
  endfunction

  task automatic push(input logic b, input int ph);
    rb[nraw] = b;
    rp[nraw] = ph;
    nraw++;
  endtask

  task automatic emit(input logic [1:0] s, input int ph, input logic st);
    es[ns]  = s;
    eph[ns] = ph;
    est[ns] = st;
    ns++;
  endtask

  task automatic build(input int k, input logic t, input logic [63:0] d);
    logic [7:0]  pid;
    logic [15:0] c;
    logic        lvl;
    int          run;
    nraw = 0;
    for (int i = 0; i < 8; i++) push(i == 7, 0);
    pid = bench_pid(k, t);
    for (int i = 0; i < 8; i++) push(pid[i], 1);
    if (k == 3) begin
      for (int i = 0; i < 64; i++) push(d[i], 2);
      c = bench_crc(d);
      for (int i = 0; i < 16; i++) push(c[i], 3);
    end
    ns  = 0;
    lvl = 1'b1;
    run = 0;
    for (int i = 0; i < nraw; i++) begin
      if (run == 6) begin
        lvl = ~lvl;
        emit(lvl ? 2'b10 : 2'b01, rp[i], 1'b1);
        run = 0;
      end
      if (!rb[i]) lvl = ~lvl;
      emit(lvl ? 2'b10 : 2'b01, rp[i], 1'b0);
      run = rb[i] ? run + 1 : 0;
    end
    if (run == 6) begin
      lvl = ~lvl;
      emit(lvl ? 2'b10 : 2'b01, 4, 1'b1);
    end
    emit(2'b00, 4, 1'b0);
    emit(2'b00, 4, 1'b0);
    emit(2'b10, 4, 1'b0);
  endtask

  task automatic tick();
    @(negedge clk) bit_en = 1'b1;
    @(negedge clk) bit_en = 1'b0;
  endtask

  task automatic gap();
    int g;
    g = $urandom_range(0, 2);
    repeat (g) @(negedge clk);
  endtask

  task automatic idle_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick();
      chk(!line_oe && !dp_o && !dm_o && !busy && !done, "R2", "idle lines",
          {line_oe, dp_o, dm_o, busy, done}, 0);
      gap();
    end
  endtask

  task automatic run_packet(input int k, input logic t, input logic [63:0] d,
                            input bit poke);
    int         mis    [0:5];
    logic [2:0] fa     [0:5];
    logic [2:0] fe     [0:5];
    int         rd_bad, bsy_bad, oe_cnt, b, total, nstuff;
    logic       rel_oe, rel_busy, rel_done, fin_done, fin_busy, post_done;
    logic       exp_rd;
    build(k, t, d);
    req_kind = 2'(k);
    data_tog = t;
    tx_bytes = d;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy && !line_oe && !rd_req, "R10", "busy after start",
        {busy, line_oe, rd_req}, 3'b100);
    bsy_bad = 0;
    for (int i = 0; i < ns; i++) begin
      tick();
      got[i]    = {dp_o, dm_o};
      got_oe[i] = line_oe;
      got_rd[i] = rd_req;
      if (!busy || done) bsy_bad++;
      if (poke && i == 10) begin
        // R12: foreign launch mid-packet
        start    = 1'b1;
        req_kind = 2'((k + 1) % 4);
        data_tog = ~t;
        @(negedge clk);
        start    = 1'b0;
        req_kind = 2'(k);
        data_tog = t;
      end
      gap();
    end
    tick();
    rel_oe = line_oe; rel_busy = busy; rel_done = done;
    tick();
    fin_done = done; fin_busy = busy;
    @(negedge clk);
    post_done = done;

    for (int s = 0; s < 6; s++) begin mis[s] = 0; fa[s] = '0; fe[s] = '0; end
    rd_bad = 0; oe_cnt = 0; nstuff = 0;
    for (int i = 0; i < ns; i++) begin
      b = est[i] ? 5 : eph[i];
      if (est[i]) nstuff++;
      if (got_oe[i]) oe_cnt++;
      if (!got_oe[i] || got[i] != es[i]) begin
        if (mis[b] == 0) begin
          fa[b] = {got_oe[i], got[i]};
          fe[b] = {1'b1, es[i]};
        end
        mis[b]++;
      end
      exp_rd = (i + 1 < ns) && (eph[i+1] == 2);
      if (got_rd[i] != exp_rd) rd_bad++;
    end
    if (rel_oe) oe_cnt++;
    total = mis[0] + mis[1] + mis[2] + mis[3] + mis[4] + mis[5];

    chk(mis[0] == 0, "R3", "sync field", fa[0], fe[0]);
    chk(mis[1] == 0, "R4", "pid field", fa[1], fe[1]);
    if (k == 3) begin
      chk(mis[2] == 0, "R5", "payload field", fa[2], fe[2]);
      chk(mis[3] == 0, "R6", "crc field", fa[3], fe[3]);
    end else begin
      chk(oe_cnt == 19, "R13", "handshake driven bit times", oe_cnt, 19);
    end
    if (nstuff > 0) chk(mis[5] == 0, "R7", "stuff bits", fa[5], fe[5]);
    chk(mis[4] == 0 && !rel_oe, "R9", "end of packet and release",
        {rel_oe, fa[4]}, {1'b0, fe[4]});
    chk(total == 0, "R8", "line symbols mismatched", total, 0);
    chk(rd_bad == 0, "R11", "rd_req timing mismatches", rd_bad, 0);
    chk(bsy_bad == 0 && rel_busy && !rel_done && fin_done && !fin_busy && !post_done,
        "R10", "busy/done handshake",
        {bsy_bad[3:0], rel_busy, rel_done, fin_done, fin_busy, post_done},
        9'b0_0001_0100);
    if (poke) chk(total == 0 && rd_bad == 0, "R12", "start while busy altered packet",
                  total + rd_bad, 0);
    idle_ticks(2);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    int          k;
    logic        t;
    logic [63:0] d;
    bit          poke;
    seed_v = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    chk(!line_oe && !busy && !done && !rd_req, "R1", "state in reset",
        {line_oe, busy, done, rd_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!line_oe && !busy && !done && !rd_req, "R1", "state after reset",
        {line_oe, busy, done, rd_req}, 0);
    idle_ticks(3);

    // directed corners
    run_packet(0, 1'b0, 64'h0, 1'b0);
    run_packet(1, 1'b0, 64'h0, 1'b0);
    run_packet(2, 1'b1, 64'h0, 1'b0);
    run_packet(3, 1'b0, 64'h0, 1'b0);
    run_packet(3, 1'b1, {64{1'b1}}, 1'b1);
    run_packet(3, 1'b0, 64'h0123_4567_89AB_CDEF, 1'b0);
    run_packet(3, 1'b1, 64'h8000_0000_0000_003F, 1'b0);
    run_packet(0, 1'b0, 64'h0, 1'b1);

    // constrained random
    for (int n = 0; n < 24; n++) begin
      k = $urandom_range(0, 3);
      t = 1'($urandom % 2);
      d = {$urandom, $urandom};
      if ($urandom % 2 == 0) begin
        for (int bi = 0; bi < 8; bi++)
          if ($urandom % 2 == 0) d[bi*8 +: 8] = 8'hFF;
      end
      poke = ($urandom % 4 == 0);
      run_packet(k, t, d, poke);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule